// File: doc/BRIEF.md
# Supply Supervisor Reset Timer

This block is the digital half of a processor supervisor. An analog comparator elsewhere reports whether the supply rail sits above its trip threshold. That flag, and the chip-select line of the serial port, enter the block through two-flop synchronisers. The block holds a system reset asserted from power-up and through every brownout. It releases the reset only after the synchronised supply flag has stayed good for a fixed number of clock cycles. Any dip in the flag restarts that wait from zero.

An optional watchdog watches the synchronised chip select. When the watchdog is enabled and no falling edge arrives within the timeout, the block asserts reset. This happens whether the line idles high or idles low. A watchdog reset is held for the same hold period as a supply reset. After the release, the watchdog counts again from zero. The enable comes from a status register in the same clock domain. While it is low, the watchdog count stays at zero. The pin polarity of the reset output is chosen by a parameter, so one design serves boards with an active-low reset and boards with an active-high reset.

Top module: `sup_supervisor`

## Requirements
- R1: While `arst_n` is low, the reset output is at its asserted level.
- R2: After `arst_n` rises with `supply_ok_i` already high, reset is released exactly HOLD_CYCLES+2 rising clock edges after the first edge following the release of `arst_n`. The two extra edges are the synchroniser stages.
- R3: When `supply_ok_i` falls, reset is asserted after the second rising edge that samples it low. It is not asserted after the first such edge.
- R4: Once `supply_ok_i` returns high, reset is released HOLD_CYCLES+2 edges after the first edge that samples it high. A dip of even one cycle during that wait clears the count, and the full wait starts again from the end of the dip.
- R5: With RST_ACTIVE_HIGH=1, `rst_o` is 1 while reset is asserted and 0 otherwise. With RST_ACTIVE_HIGH=0, the levels are inverted.
- R6: With the watchdog enabled and reset released, reset is asserted WDOG_CYCLES+1 edges after the count starts if no falling edge of chip select arrives. This holds whether chip select idles high or idles low. The count starts at release, at enable, or at the edge that registers a falling edge.
- R7: A falling edge of chip select restarts the watchdog count. It takes effect three edges after the edge that first samples the pin low. A rising edge of chip select does not restart the count.
- R8: A watchdog reset stays asserted for exactly HOLD_CYCLES edges and is then released. The watchdog count restarts from zero at that release.
- R9: While `wdog_en_i` is low, the watchdog count is held at zero and never asserts reset, however long chip select idles. Raising `wdog_en_i` starts a fresh count of the full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok_i | input | 1 | Raw comparator flag, high when the supply is above the trip level |
| chip_sel_n_i | input | 1 | Raw active-low chip select of the serial port, watched by the watchdog |
| wdog_en_i | input | 1 | Watchdog enable from the status register (same clock domain) |
| rst_o | output | 1 | System reset, polarity set by RST_ACTIVE_HIGH |

## Verification
The embedded assertions check several things on every cycle. A low synchronised supply flag clears the hold count and the release on the next edge. A release occurs only from the last hold count. A watchdog bite needs a full count and lasts one cycle. The watchdog count stays at zero while disabled and after a kick. A bite forces the reset pin to its asserted level. The absolute latencies are shown only by the bench scenarios, each counted edge by edge from a stimulus. These cover the power-up wait, brownout entry and exit, a glitch that restarts the wait, and watchdog expiry with chip select idling high and idling low. They also cover kicks that hold the watchdog off, a rising edge that must not count as a kick, and re-enabling after a disable. Two instances with opposite polarity are compared at every scenario check.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Depth of every input synchroniser in the supervisor.
    localparam int unsigned SYNC_DEPTH = 2;

    // Convert an internal "reset wanted" flag into the pin level.
    function automatic logic pin_level(input bit active_high, input logic asserted);
        return active_high ? asserted : ~asserted;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= {STAGES{RST_VAL}};
        else         s_q <= s_d;
    end

    assign q_o = s_q.chain[STAGES-1];

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic good_i,      // synchronised supply flag
    input  logic bite_i,      // one-cycle watchdog expiry
    output logic released_o
);

    localparam int unsigned     CW   = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0]   LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          released;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!good_i || bite_i) begin
            h_d.cnt      = '0;
            h_d.released = 1'b0;
        end else if (!h_q.released) begin
            if (h_q.cnt == LAST) begin
                h_d.cnt      = '0;
                h_d.released = 1'b1;
            end else begin
                h_d.cnt = h_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) h_q <= '0;
        else         h_q <= h_d;
    end

    assign released_o = h_q.released;

    // A low supply flag wipes any progress toward release (R4).
    assert_drop_clears_R4: assert property (@(posedge clk) disable iff (!arst_n)
        !good_i |=> (!h_q.released && h_q.cnt == '0));

    // Release only ever follows the final hold count (R2).
    assert_release_after_hold_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(h_q.released) |-> ($past(h_q.cnt) == LAST));

    // A watchdog bite drops the release on the next edge (R8).
    assert_bite_drops_release_R8: assert property (@(posedge clk) disable iff (!arst_n)
        bite_i |=> !h_q.released);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int unsigned WDOG_CYCLES = 350_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en_i,        // watchdog enable
    input  logic armed_i,     // reset currently released
    input  logic cs_i,        // synchronised active-low chip select
    output logic bite_o
);

    localparam int unsigned   CW   = $clog2(WDOG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          cs_prev;
        logic          bite;
    } wdog_t;

    wdog_t w_d, w_q;
    logic  kick;

    assign kick = w_q.cs_prev & ~cs_i;

    always_comb begin
        w_d         = w_q;
        w_d.cs_prev = cs_i;
        w_d.bite    = 1'b0;
        if (!en_i || !armed_i || kick || w_q.bite) begin
            w_d.cnt = '0;
        end else if (w_q.cnt == LAST) begin
            w_d.cnt  = '0;
            w_d.bite = 1'b1;
        end else begin
            w_d.cnt = w_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            w_q.cnt     <= '0;
            w_q.cs_prev <= 1'b1;
            w_q.bite    <= 1'b0;
        end else begin
            w_q <= w_d;
        end
    end

    assign bite_o = w_q.bite;

    // Disabled watchdog keeps its count at zero (R9).
    assert_idle_when_disabled_R9: assert property (@(posedge clk) disable iff (!arst_n)
        !en_i |=> (w_q.cnt == '0 && !w_q.bite));

    // A falling chip-select edge restarts the count (R7).
    assert_kick_restarts_R7: assert property (@(posedge clk) disable iff (!arst_n)
        kick |=> (w_q.cnt == '0));

    // Expiry needs the full count and lasts one cycle (R6).
    assert_bite_full_count_R6: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(w_q.bite) |-> ($past(w_q.cnt) == LAST));
    assert_bite_single_R6: assert property (@(posedge clk) disable iff (!arst_n)
        w_q.bite |=> !w_q.bite);
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!arst_n)
        w_q.cnt <= LAST);

endmodule

// File: rtl/sup_supervisor.sv
module sup_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES     = 50_000_000,
    parameter int unsigned WDOG_CYCLES     = 350_000_000,
    parameter bit          RST_ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok_i,
    input  logic chip_sel_n_i,
    input  logic wdog_en_i,
    output logic rst_o
);

    localparam logic ASSERT_LVL = pin_level(RST_ACTIVE_HIGH, 1'b1);

    logic good_s, cs_s, released, bite, rst_wanted;

    sup_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_good (
        .clk(clk), .arst_n(arst_n), .d_i(supply_ok_i), .q_o(good_s));

    sup_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .arst_n(arst_n), .d_i(chip_sel_n_i), .q_o(cs_s));

    sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .arst_n(arst_n), .good_i(good_s), .bite_i(bite),
        .released_o(released));

    sup_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
        .clk(clk), .arst_n(arst_n), .en_i(wdog_en_i), .armed_i(released),
        .cs_i(cs_s), .bite_o(bite));

    // Assert straight away on a bad flag; release only from the timer.
    assign rst_wanted = ~released | ~good_s;
    assign rst_o      = pin_level(RST_ACTIVE_HIGH, rst_wanted);

    // A watchdog bite shows on the pin one edge later (R8).
    assert_bite_forces_reset_R8: assert property (@(posedge clk) disable iff (!arst_n)
        bite |=> (rst_o == ASSERT_LVL));

    // A disabled watchdog never produces a bite (R9).
    assert_no_bite_disabled_R9: assert property (@(posedge clk) disable iff (!arst_n)
        !wdog_en_i |=> !bite);

    // The pin is asserted whenever the release flag is low (R5).
    assert_pin_polarity_R5: assert property (@(posedge clk) disable iff (!arst_n)
        !released |-> (rst_o == ASSERT_LVL));

endmodule

// File: tb/tb_sup_supervisor.sv
module tb_sup_supervisor;

    localparam int unsigned H = 20;
    localparam int unsigned W = 30;

    logic clk = 1'b0;
    logic arst_n, supply_ok, cs_n, wdog_en;
    logic rst_hi, rst_lo;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    typedef struct {
        int    c;
        logic  lvl;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t item;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    sup_supervisor #(.HOLD_CYCLES(H), .WDOG_CYCLES(W), .RST_ACTIVE_HIGH(1'b1)) dut (
        .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok), .chip_sel_n_i(cs_n),
        .wdog_en_i(wdog_en), .rst_o(rst_hi));

    sup_supervisor #(.HOLD_CYCLES(H), .WDOG_CYCLES(W), .RST_ACTIVE_HIGH(1'b0)) dut_lo (
        .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok), .chip_sel_n_i(cs_n),
        .wdog_en_i(wdog_en), .rst_o(rst_lo));

    // Driver side: queue the expected reset level for a given cycle.
    task automatic expect_at(input int c, input logic lvl, input string tag);
        exp_t e;
        e.c = c; e.lvl = lvl; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
        #1;
    endtask

    // Monitor: compare both polarities at mid-cycle.
    always @(negedge clk) begin
        while (exp_q.size() != 0 && exp_q[0].c <= cyc) begin
            item = exp_q.pop_front();
            checks++;
            if (item.c != cyc || rst_hi !== item.lvl) begin
                errors++;
                $display("FAIL %s cyc %0d: active-high pin actual=%b expected=%b", item.tag, cyc, rst_hi, item.lvl);
            end
            checks++;
            if (rst_lo !== ~item.lvl) begin
                errors++;
                $display("FAIL R5 cyc %0d: active-low pin actual=%b expected=%b", cyc, rst_lo, ~item.lvl);
            end
        end
    end

    initial begin : watchdog_timer
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        arst_n = 1'b0; supply_ok = 1'b1; cs_n = 1'b1; wdog_en = 1'b0;
        expect_at(3, 1'b1, "R1");
        // R2: power-up wait.
        wait_to(5);  arst_n = 1'b1;
        expect_at(5 + 1 + H, 1'b1, "R2");
        expect_at(5 + 2 + H, 1'b0, "R2");
        // R3: brownout entry after two synchroniser edges.
        wait_to(40); supply_ok = 1'b0;
        expect_at(41, 1'b0, "R3");
        expect_at(42, 1'b1, "R3");
        // R4: recovery with a one-cycle glitch restarting the wait.
        wait_to(50); supply_ok = 1'b1;
        wait_to(60); supply_ok = 1'b0;
        wait_to(61); supply_ok = 1'b1;
        expect_at(50 + 1 + H, 1'b1, "R4");
        expect_at(63 + H - 1, 1'b1, "R4");
        expect_at(63 + H, 1'b0, "R4");
        // R9: watchdog disabled, chip select idle.
        expect_at(150, 1'b0, "R9");
        expect_at(199, 1'b0, "R9");
        // R6 idle high, then R8 hold after the bite.
        wait_to(200); wdog_en = 1'b1;
        expect_at(200 + W, 1'b0, "R6");
        expect_at(200 + W + 1, 1'b1, "R6");
        expect_at(200 + W + H, 1'b1, "R8");
        expect_at(200 + W + H + 1, 1'b0, "R8");
        // R7 kicks keep it quiet; last kick leaves chip select low (R6 idle low).
        expect_at(300, 1'b0, "R7");
        expect_at(330, 1'b0, "R7");
        expect_at(360, 1'b0, "R7");
        expect_at(340 + W + 3, 1'b0, "R6");
        expect_at(340 + W + 4, 1'b1, "R6");
        expect_at(340 + W + 3 + H, 1'b1, "R8");
        expect_at(340 + W + 4 + H, 1'b0, "R8");
        for (int k = 0; k < 5; k++) begin
            wait_to(260 + 20 * k); cs_n = 1'b0;
            if (k < 4) begin
                wait_to(270 + 20 * k); cs_n = 1'b1;
            end
        end
        // R7: a rising edge is not a kick; count runs from release at 394.
        wait_to(404); cs_n = 1'b1;
        expect_at(394 + W, 1'b0, "R7");
        expect_at(394 + W + 1, 1'b1, "R7");
        expect_at(394 + W + 1 + H, 1'b0, "R8");
        // R9: disable mid-count, then re-enable for a fresh count.
        wait_to(460); wdog_en = 1'b0;
        expect_at(500, 1'b0, "R9");
        expect_at(520, 1'b0, "R9");
        wait_to(530); wdog_en = 1'b1;
        expect_at(530 + W, 1'b0, "R9");
        expect_at(530 + W + 1, 1'b1, "R9");
        expect_at(530 + W + H, 1'b1, "R8");
        expect_at(530 + W + H + 1, 1'b0, "R8");
        wait_to(600);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule